// File: doc/BRIEF.md
# Overhead Byte Serial Drop Ports

This block takes the section and line overhead bytes that an upstream extractor pulls out of each 125 µs frame. It presents them on five dedicated serial drop ports: the section orderwire, the user channel, the section data channel (three bytes), the line orderwire, and the line data channel (nine bytes). Each byte arrives as a value and a 4-bit byte identifier, qualified by a valid strobe. The block keeps the latest value of every identifier seen during the current frame. At the next frame boundary it hands the whole set to the output side.

Each port shifts its bytes out most significant bit first. Its bit rate follows from its byte count per frame: 64 kbit/s for the one-byte ports, 192 kbit/s for the section data channel and 576 kbit/s for the line data channel. The rates are not separate clocks. They are derived from the system clock by dividing a parameterized frame length, in system clock cycles, into equal bit periods. Each port gives a one-cycle clock enable with every new bit and a frame sync pulse with the first bit of each frame. A downstream serial sink samples the data whenever the enable is high.

Top module: `ovh_serial_drop`

## Requirements
- R1: While rst_n is low, all drop_sd, drop_ce and drop_sync outputs are 0. The first frame after reset shifts out all-zero bytes on every port.
- R2: Byte identifiers map to ports as follows: 0 to port 0 (section orderwire), 1 to port 1 (user channel), 2..4 to port 2 (section data, bytes 0..2), 5 to port 3 (line orderwire), and 6..14 to port 4 (line data, bytes 0..8).
- R3: Every port raises drop_sync for one cycle every FRAME_CYC cycles, on all ports in the same cycle, and only together with that port's drop_ce for the first bit of the frame.
- R4: Port p raises drop_ce exactly once every FRAME_CYC/(8*N) cycles, where N is 1, 1, 3, 1, 9 for ports 0..4. This gives 8*N enables per frame.
- R5: Within a port, bytes go out in ascending identifier order, each most significant bit first. drop_sd changes only in a cycle where drop_ce is high.
- R6: A byte written during frame N is shifted out during frame N+1.
- R7: A byte identifier not written during a frame repeats its previous value in the following frame.
- R8: A write with ovh_vld low, or with identifier 15, changes no port's output.
- R9: When one identifier is written more than once in a frame, the last value written is the one shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovh_vld | input | 1 | Qualifies ovh_id and ovh_byte for one cycle |
| ovh_id | input | 4 | Overhead byte identifier (R2 mapping, 15 = none) |
| ovh_byte | input | 8 | Overhead byte value |
| drop_sd | output | 5 | Serial data, one bit per port |
| drop_ce | output | 5 | Per-port bit enable, high for one cycle as each bit starts |
| drop_sync | output | 5 | Per-port frame sync, high with the first bit of a frame |

## Verification
The bench drives full frames of distinct per-identifier values first, so that a wrong identifier-to-port mapping or wrong byte order shows up as a bit mismatch. A frame with no writes then separates the repeat behaviour from a buffer that clears. A frame mixing ignored writes (strobe low, identifier 15) with a single real write tells a correct decoder from one that leaks. Frames with repeated writes to one identifier, and with all-ones and all-zero data, catch first-write-wins logic and stuck shift bits, while bit-period and sync timing are checked at every enable.

// File: rtl/ovh_drop_pkg.sv
package ovh_drop_pkg;
    localparam int NPORTS  = 5;
    localparam int ID_W    = 4;
    localparam int ID_NONE = 15;

    // bytes per frame carried by each port
    function automatic int port_nbytes(int p);
        case (p)
            2:       return 3;
            4:       return 9;
            default: return 1;
        endcase
    endfunction

    // first byte identifier owned by each port
    function automatic int port_base(int p);
        case (p)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 5;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/ovh_frame_timer.sv
module ovh_frame_timer #(
    parameter int FRAME_CYC = 15624
) (
    input  logic clk,
    input  logic rst_n,
    output logic fstart
);
    localparam int CW = $clog2(FRAME_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CW'(FRAME_CYC - 1))
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fstart = (s_q.cnt == '0);
endmodule

// File: rtl/ovh_drop_port.sv
module ovh_drop_port
    import ovh_drop_pkg::*;
#(
    parameter int NB        = 1,
    parameter int BASE      = 0,
    parameter int FRAME_CYC = 15624
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fstart,
    input  logic            wr_vld,
    input  logic [ID_W-1:0] wr_id,
    input  logic [7:0]      wr_byte,
    output logic            sd,
    output logic            ce,
    output logic            sync
);
    localparam int W       = NB * 8;
    localparam int BIT_CYC = FRAME_CYC / W;
    localparam int BCW     = $clog2(BIT_CYC + 1);

    typedef struct packed {
        logic [W-1:0]   cap;   // bytes gathered in the current frame
        logic [W-1:0]   sh;    // bytes being serialized
        logic [BCW-1:0] bcnt;
        logic           ce;
        logic           sync;
    } port_t;

    port_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ce   = 1'b0;
        s_d.sync = 1'b0;
        // capture side: byte 0 sits in the top byte lane
        for (int i = 0; i < NB; i++) begin
            if (wr_vld && wr_id == ID_W'(BASE + i))
                s_d.cap[(NB-1-i)*8 +: 8] = wr_byte;
        end
        // output side: swap at frame start, shift at each bit period
        if (fstart) begin
            s_d.sh   = s_q.cap;
            s_d.bcnt = '0;
            s_d.ce   = 1'b1;
            s_d.sync = 1'b1;
        end else if (s_q.bcnt == BCW'(BIT_CYC - 1)) begin
            s_d.bcnt = '0;
            s_d.sh   = s_q.sh << 1;
            s_d.ce   = 1'b1;
        end else begin
            s_d.bcnt = s_q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sd   = s_q.sh[W-1];
    assign ce   = s_q.ce;
    assign sync = s_q.sync;
endmodule

// File: rtl/ovh_serial_drop.sv
module ovh_serial_drop
    import ovh_drop_pkg::*;
#(
    parameter int FRAME_CYC = 15624
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovh_vld,
    input  logic [ID_W-1:0]   ovh_id,
    input  logic [7:0]        ovh_byte,
    output logic [NPORTS-1:0] drop_sd,
    output logic [NPORTS-1:0] drop_ce,
    output logic [NPORTS-1:0] drop_sync
);
    logic fstart;

    ovh_frame_timer #(.FRAME_CYC(FRAME_CYC)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fstart (fstart)
    );

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
        ovh_drop_port #(
            .NB        (port_nbytes(gp)),
            .BASE      (port_base(gp)),
            .FRAME_CYC (FRAME_CYC)
        ) i_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .fstart  (fstart),
            .wr_vld  (ovh_vld),
            .wr_id   (ovh_id),
            .wr_byte (ovh_byte),
            .sd      (drop_sd[gp]),
            .ce      (drop_ce[gp]),
            .sync    (drop_sync[gp])
        );
    end
endmodule

// File: rtl/ovh_serial_drop_chk.sv
module ovh_serial_drop_chk
    import ovh_drop_pkg::*;
#(
    parameter int FRAME_CYC = 15624
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] drop_sd,
    input logic [NPORTS-1:0] drop_ce,
    input logic [NPORTS-1:0] drop_sync
);
    logic [31:0] cnt_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (drop_sync[0]) begin
            cnt_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R3: frame sync period
    p_frame_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (drop_sync[0] == (cnt_q == 32'(FRAME_CYC - 1))));

    // R3: all ports share the frame sync
    p_sync_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_sync == '0) || (drop_sync == '1));

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_chk
        // R3: sync only with a bit enable
        p_sync_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
            drop_sync[gp] |-> drop_ce[gp]);
        // R4: bit enables are single-cycle pulses
        p_ce_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
            drop_ce[gp] |=> !drop_ce[gp]);
        // R5: serial data moves only on a bit enable
        p_sd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(drop_sd[gp]) |-> drop_ce[gp]);
    end
endmodule

bind ovh_serial_drop ovh_serial_drop_chk #(.FRAME_CYC(FRAME_CYC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drop_sd   (drop_sd),
    .drop_ce   (drop_ce),
    .drop_sync (drop_sync)
);

// File: tb/test_ovh_serial_drop.sv
`timescale 1ns/1ps
module test_ovh_serial_drop;
    import ovh_drop_pkg::*;

    localparam int FRAME_CYC = 720;

    typedef struct packed {
        logic       sync;
        logic       bit_v;
        logic [3:0] req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ovh_vld = 1'b0;
    logic [ID_W-1:0]   ovh_id = '0;
    logic [7:0]        ovh_byte = '0;
    logic [NPORTS-1:0] drop_sd, drop_ce, drop_sync;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] model [15];
    item_t q0[$], q1[$], q2[$], q3[$], q4[$];
    int  last_ce [NPORTS];
    bit  have_ce [NPORTS];

    ovh_serial_drop #(.FRAME_CYC(FRAME_CYC)) i_ovh_serial_drop (
        .clk(clk), .rst_n(rst_n), .ovh_vld(ovh_vld), .ovh_id(ovh_id),
        .ovh_byte(ovh_byte), .drop_sd(drop_sd), .drop_ce(drop_ce),
        .drop_sync(drop_sync)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic push(int p, item_t it);
        case (p)
            0: q0.push_back(it);
            1: q1.push_back(it);
            2: q2.push_back(it);
            3: q3.push_back(it);
            default: q4.push_back(it);
        endcase
    endtask

    function automatic int qsize(int p);
        case (p)
            0: return q0.size();
            1: return q1.size();
            2: return q2.size();
            3: return q3.size();
            default: return q4.size();
        endcase
    endfunction

    function automatic item_t qpop(int p);
        case (p)
            0: return q0.pop_front();
            1: return q1.pop_front();
            2: return q2.pop_front();
            3: return q3.pop_front();
            default: return q4.pop_front();
        endcase
    endfunction

    // expected serial stream of the next frame from the byte model
    task automatic push_frame(logic [3:0] req);
        for (int p = 0; p < NPORTS; p++)
            for (int i = 0; i < port_nbytes(p); i++)
                for (int b = 7; b >= 0; b--) begin
                    item_t it;
                    it.sync  = (i == 0 && b == 7);
                    it.bit_v = model[port_base(p) + i][b];
                    it.req   = req;
                    push(p, it);
                end
    endtask

    task automatic wr(int id, logic [7:0] v, bit vld);
        @(negedge clk);
        ovh_vld  = vld;
        ovh_id   = ID_W'(id);
        ovh_byte = v;
        if (vld && id < ID_NONE) model[id] = v;
        @(negedge clk);
        ovh_vld = 1'b0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!drop_sync[0]);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            // R1: outputs quiet during reset
            check(drop_sd == '0 && drop_ce == '0 && drop_sync == '0, "R1",
                  {drop_sd, drop_ce, drop_sync}, 0);
        end else if (!done) begin
            if (drop_sync != '0)
                check(drop_sync == '1, "R3", drop_sync, 5'h1f);
            for (int p = 0; p < NPORTS; p++) begin
                if (drop_sync[p] && !drop_ce[p])
                    check(0, "R3", 0, 1);
                if (drop_ce[p]) begin
                    if (have_ce[p])
                        check(cyc - last_ce[p] == FRAME_CYC / (8 * port_nbytes(p)),
                              "R4", cyc - last_ce[p], FRAME_CYC / (8 * port_nbytes(p)));
                    have_ce[p] = 1;
                    last_ce[p] = cyc;
                    if (qsize(p) == 0) begin
                        check(0, "R4", p, -1);
                    end else begin
                        item_t it;
                        it = qpop(p);
                        checks++;
                        if (drop_sd[p] !== it.bit_v || drop_sync[p] !== it.sync) begin
                            errors++;
                            $display("FAIL R%0d port %0d actual sd=%0b sync=%0b expected sd=%0b sync=%0b t=%0t",
                                     it.req, p, drop_sd[p], drop_sync[p], it.bit_v, it.sync, $time);
                        end
                    end
                end
            end
        end
    end

    // driver
    initial begin
        for (int i = 0; i < 15; i++) model[i] = 8'h00;
        for (int p = 0; p < NPORTS; p++) begin have_ce[p] = 0; last_ce[p] = 0; end
        push_frame(4'd1);                        // R1: first frame all zeros
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        wait_sync();                             // R2, R6: distinct values per id
        for (int id = 0; id < 15; id++) wr(id, 8'(8'h13 + id * 29), 1);
        push_frame(4'd2);

        wait_sync();                             // R7: no writes, repeat
        push_frame(4'd7);

        wait_sync();                             // R8: ignored writes plus one real
        for (int id = 0; id < 15; id++) wr(id, 8'hEE, 0);
        wr(15, 8'h33, 1);
        wr(3, 8'hC3, 1);
        push_frame(4'd8);

        wait_sync();                             // R9: last write wins
        wr(0, 8'h01, 1); wr(0, 8'h80, 1);
        wr(14, 8'h55, 1); wr(14, 8'hAA, 1);
        wr(7, 8'h0F, 1); wr(7, 8'hF0, 1);
        push_frame(4'd9);

        wait_sync();                             // R5: all ones
        for (int id = 0; id < 15; id++) wr(id, 8'hFF, 1);
        push_frame(4'd5);

        wait_sync();                             // R5, R6: nibble patterns
        for (int id = 0; id < 15; id++) wr(id, {4'(id), ~4'(id)}, 1);
        push_frame(4'd6);

        wait_sync();                             // R6: all zeros
        for (int id = 0; id < 15; id++) wr(id, 8'h00, 1);
        push_frame(4'd6);

        wait_sync();
        repeat (FRAME_CYC - 4) @(negedge clk);
        for (int p = 0; p < NPORTS; p++)
            check(qsize(p) == 0, "R4", qsize(p), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule